// File: doc/BRIEF.md
# SMBus Transfer Sequencer

This block runs one complete byte or word transfer, read or write, against a register-mapped SMBus controller on behalf of a client. The client pulses `start` with a target address, a command byte, write data and two mode bits. The sequencer then drives the controller's 32-bit register port through a fixed sequence. It first records the controller's control register. It then writes a new control value that stops background temperature-sensor polling. It polls the status register until the controller is idle, and writes the command register, which launches the SMBus operation.

After launch, the sequencer polls status for the completion flag that belongs to the operation. It classifies the result, hands back read data, and writes the recorded control value back before it signals `done`. All waits are counted in milliseconds derived from a clock prescaler parameter, so a test can shrink them without changing the structure.

The register port has a fixed timing. A read strobe (`reg_en` high, `reg_we` low) in one cycle returns its data on `reg_rdata` in the next cycle. A write takes effect in the cycle it is strobed.

Top module: `smbus_xfer_seq`

## Requirements
- R1: The first register access after an accepted start is a read of the control register. The last access before `done` is a write of that same read value back to the control register, whatever the outcome.
- R2: The first control write equals the recorded value with these changes: bits [31:28] take address bits [7:4], bit 27 is set, and bits 26 and 9 are cleared. All other bits are kept.
- R3: The command write has bit 31 set, bit 29 equal to `is_word` and bit 27 equal to `is_write`. Address bits [3:1] go in [26:24] and the command byte in [23:16]. Bits 30 and 28 are zero. Bits [15:0] depend on the operation: a word write puts `wr_data` there byte-swapped, a byte write puts `{8'h00, wr_data[7:0]}`, and a read puts zero.
- R4: Register select codes are 0 for control, 1 for command and 2 for status. Each transfer makes exactly two control writes and one command write. The command write comes after the first control write and after at least one status read. No register access occurs while idle.
- R5: Before the command write, status bit 31 (busy) is read. If it is set, the sequencer waits POLL_MS milliseconds and reads it again, for at most POLL_TRIES reads. If it is busy on every read, `settle_warn` is high at `done` and the transfer still proceeds.
- R6: After the command write, status is polled until the matching flag is seen. That flag is bit 28 for a write and bit 29 for a read. The other flag is ignored. `status` is then 0 (ok) unless R8 applies.
- R7: If the matching flag is not seen within DONE_MS milliseconds after the command write, `status` is 1 (timeout).
- R8: If status bit 30 is set together with the matching flag, `status` is 2 (bus error). The exception is an address with upper nibble 4'h6, which completes with status 0.
- R9: A successful word read returns status bits [15:0] byte-swapped on `rd_data`. A successful byte read returns `{8'h00, bits[7:0]}`. Writes and failed transfers return zero.
- R10: `done` is a one-cycle pulse, after which `busy` is low. `busy` is high from the cycle after the accepting edge until `done`. With an idle controller and an immediate completion, `done` is high after the 9th clock edge following the edge that samples `start`.
- R11: A `start` pulse while a transfer is in progress is ignored. No second transfer is queued.
- R12: After reset, `busy`, `done`, `reg_en`, `settle_warn`, `status` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only when idle |
| tgt_addr | input | 8 | Target address, bit 0 unused |
| cmd_byte | input | 8 | Command/offset byte |
| wr_data | input | 16 | Data for write operations |
| is_word | input | 1 | 1 = word transfer, 0 = byte transfer |
| is_write | input | 1 | 1 = write, 0 = read |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result, valid at done |
| status | output | 2 | 0 ok, 1 timeout, 2 bus error |
| settle_warn | output | 1 | Controller never went idle before launch |
| reg_en | output | 1 | Register access strobe |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_sel | output | 2 | 0 control, 1 command, 2 status |
| reg_wdata | output | 32 | Register write data |
| reg_rdata | input | 32 | Register read data, one cycle after a read strobe |

## Verification
On the fast path, `done` is due exactly 9 edges after the accepting edge, and the bench counts falling edges from the start cycle to confirm that figure. The results of a slow path are sampled only at the falling edge where `done` is high. For timeouts, the bench checks that at least DONE_MS×TICKS_PER_MS cycles have passed. For settle waits, it checks the number of status reads made before launch rather than the exact cycle. Register traffic is captured by a controller model that answers reads one cycle later. Each captured word is therefore compared after `done`, never at the edge that writes it.

// File: rtl/smbseq_pkg.sv
package smbseq_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_CMD  = 2'd1,
    SEL_STAT = 2'd2
  } regsel_e;

  typedef enum logic [1:0] {
    XS_OK      = 2'd0,
    XS_TIMEOUT = 2'd1,
    XS_BUSERR  = 2'd2
  } xstat_e;

  // status register bit positions
  localparam int unsigned ST_BUSY   = 31;
  localparam int unsigned ST_ERR    = 30;
  localparam int unsigned ST_RVALID = 29;
  localparam int unsigned ST_WDONE  = 28;

  // control register bit positions
  localparam int unsigned CT_CLKOVR = 27;
  localparam int unsigned CT_WRDIS  = 26;
  localparam int unsigned CT_POLLEN = 9;

  // command register bit positions
  localparam int unsigned CM_TRIG = 31;
  localparam int unsigned CM_WORD = 29;
  localparam int unsigned CM_WR   = 27;

  function automatic logic [15:0] swap16(input logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  function automatic logic [31:0] mk_ctrl(input logic [31:0] base, input logic [7:0] addr);
    logic [31:0] w;
    w            = base;
    w[31:28]     = addr[7:4];
    w[CT_CLKOVR] = 1'b1;
    w[CT_WRDIS]  = 1'b0;
    w[CT_POLLEN] = 1'b0;
    return w;
  endfunction

  function automatic logic [31:0] mk_cmd(input logic [7:0] addr, input logic [7:0] cmd,
                                         input logic [15:0] data, input logic word,
                                         input logic wr);
    logic [31:0] w;
    w          = '0;
    w[CM_TRIG] = 1'b1;
    w[CM_WORD] = word;
    w[CM_WR]   = wr;
    w[26:24]   = addr[3:1];
    w[23:16]   = cmd;
    if (wr) w[15:0] = word ? swap16(data) : {8'h00, data[7:0]};
    return w;
  endfunction

  function automatic logic is_page_sel(input logic [7:0] addr);
    return addr[7:4] == 4'h6;
  endfunction

  function automatic logic [15:0] pick_read(input logic [31:0] stat, input logic word);
    return word ? swap16(stat[15:0]) : {8'h00, stat[7:0]};
  endfunction

endpackage

// File: rtl/smbseq_timer.sv
module smbseq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/smbseq_wordgen.sv
module smbseq_wordgen
  import smbseq_pkg::*;
(
  input  logic [31:0] ctrl_saved,
  input  logic [7:0]  addr,
  input  logic [7:0]  cmd,
  input  logic [15:0] data,
  input  logic        word,
  input  logic        wr,
  output logic [31:0] ctrl_new,
  output logic [31:0] cmd_word
);
  assign ctrl_new = mk_ctrl(ctrl_saved, addr);
  assign cmd_word = mk_cmd(addr, cmd, data, word, wr);
endmodule

// File: rtl/smbseq_portdrv.sv
module smbseq_portdrv
  import smbseq_pkg::*;
(
  input  logic        op_en,
  input  logic        op_we,
  input  regsel_e     op_sel,
  input  logic        use_saved,
  input  logic [31:0] ctrl_new,
  input  logic [31:0] ctrl_saved,
  input  logic [31:0] cmd_word,
  output logic        reg_en,
  output logic        reg_we,
  output logic [1:0]  reg_sel,
  output logic [31:0] reg_wdata
);
  always_comb begin
    reg_en    = op_en;
    reg_we    = op_en & op_we;
    reg_sel   = op_en ? op_sel : SEL_CTRL;
    reg_wdata = '0;
    if (op_en && op_we) begin
      if (op_sel == SEL_CMD) reg_wdata = cmd_word;
      else                   reg_wdata = use_saved ? ctrl_saved : ctrl_new;
    end
  end
endmodule

// File: rtl/smbus_xfer_seq.sv
module smbus_xfer_seq
  import smbseq_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 100000,
  parameter int unsigned POLL_MS      = 10,
  parameter int unsigned POLL_TRIES   = 4,
  parameter int unsigned DONE_MS      = 35
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  tgt_addr,
  input  logic [7:0]  cmd_byte,
  input  logic [15:0] wr_data,
  input  logic        is_word,
  input  logic        is_write,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic [1:0]  status,
  output logic        settle_warn,
  output logic        reg_en,
  output logic        reg_we,
  output logic [1:0]  reg_sel,
  output logic [31:0] reg_wdata,
  input  logic [31:0] reg_rdata
);
  localparam int unsigned POLL_CYC = POLL_MS * TICKS_PER_MS;
  localparam int unsigned DONE_CYC = DONE_MS * TICKS_PER_MS;
  localparam int unsigned MAX_CYC  = (DONE_CYC > POLL_CYC) ? DONE_CYC : POLL_CYC;
  localparam int unsigned TW       = $clog2(MAX_CYC + 1);
  localparam int unsigned TRY_W    = $clog2(POLL_TRIES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_CTRL, S_CAP_CTRL, S_WR_CTRL, S_RD_BUSY, S_CHK_BUSY,
    S_WAIT_POLL, S_WR_CMD, S_RD_STAT, S_CHK_STAT, S_RESTORE, S_FIN
  } st_e;

  st_e               state;
  logic [7:0]        addr_q, cmd_q;
  logic [15:0]       data_q;
  logic              word_q, wr_q;
  logic [31:0]       saved_q;
  logic [TRY_W-1:0]  tries_q;
  logic [15:0]       rd_q;
  xstat_e            stat_q;
  logic              warn_q;

  logic [31:0] ctrl_new, cmd_word;
  logic        tmr_load, tmr_exp;
  logic [TW-1:0] tmr_val;

  // named internal events
  logic evt_accept, evt_cmd_wr, evt_restore, evt_flag, evt_err_hit, evt_ctrl_busy;
  assign evt_accept    = start && (state == S_IDLE);
  assign evt_cmd_wr    = (state == S_WR_CMD);
  assign evt_restore   = (state == S_RESTORE);
  assign evt_ctrl_busy = (state == S_CHK_BUSY) && reg_rdata[ST_BUSY];
  assign evt_flag      = (state == S_CHK_STAT) &&
                         (wr_q ? reg_rdata[ST_WDONE] : reg_rdata[ST_RVALID]);
  assign evt_err_hit   = evt_flag && reg_rdata[ST_ERR] && !is_page_sel(addr_q);

  smbseq_wordgen i_wordgen (
    .ctrl_saved (saved_q),
    .addr       (addr_q),
    .cmd        (cmd_q),
    .data       (data_q),
    .word       (word_q),
    .wr         (wr_q),
    .ctrl_new   (ctrl_new),
    .cmd_word   (cmd_word)
  );

  assign tmr_load = evt_ctrl_busy || evt_cmd_wr;
  assign tmr_val  = evt_cmd_wr ? TW'(DONE_CYC) : TW'(POLL_CYC);

  smbseq_timer #(.W(TW)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  // register operation per state
  logic    op_en, op_we;
  regsel_e op_sel;
  always_comb begin
    op_en  = 1'b0;
    op_we  = 1'b0;
    op_sel = SEL_CTRL;
    unique case (state)
      S_RD_CTRL:            begin op_en = 1'b1; end
      S_WR_CTRL, S_RESTORE: begin op_en = 1'b1; op_we = 1'b1; end
      S_RD_BUSY, S_RD_STAT: begin op_en = 1'b1; op_sel = SEL_STAT; end
      S_WR_CMD:             begin op_en = 1'b1; op_we = 1'b1; op_sel = SEL_CMD; end
      default:              ;
    endcase
  end

  smbseq_portdrv i_portdrv (
    .op_en      (op_en),
    .op_we      (op_we),
    .op_sel     (op_sel),
    .use_saved  (evt_restore),
    .ctrl_new   (ctrl_new),
    .ctrl_saved (saved_q),
    .cmd_word   (cmd_word),
    .reg_en     (reg_en),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      addr_q  <= '0;
      cmd_q   <= '0;
      data_q  <= '0;
      word_q  <= 1'b0;
      wr_q    <= 1'b0;
      saved_q <= '0;
      tries_q <= '0;
      rd_q    <= '0;
      stat_q  <= XS_OK;
      warn_q  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (evt_accept) begin
          addr_q  <= tgt_addr;
          cmd_q   <= cmd_byte;
          data_q  <= wr_data;
          word_q  <= is_word;
          wr_q    <= is_write;
          tries_q <= '0;
          rd_q    <= '0;
          stat_q  <= XS_OK;
          warn_q  <= 1'b0;
          state   <= S_RD_CTRL;
        end
        S_RD_CTRL:  state <= S_CAP_CTRL;
        S_CAP_CTRL: begin
          saved_q <= reg_rdata;
          state   <= S_WR_CTRL;
        end
        S_WR_CTRL:  state <= S_RD_BUSY;
        S_RD_BUSY:  state <= S_CHK_BUSY;
        S_CHK_BUSY: begin
          if (evt_ctrl_busy) begin
            tries_q <= tries_q + 1'b1;
            state   <= S_WAIT_POLL;
          end else begin
            state   <= S_WR_CMD;
          end
        end
        S_WAIT_POLL: if (tmr_exp) begin
          if (tries_q == TRY_W'(POLL_TRIES)) begin
            warn_q <= 1'b1;
            state  <= S_WR_CMD;
          end else begin
            state  <= S_RD_BUSY;
          end
        end
        S_WR_CMD:  state <= S_RD_STAT;
        S_RD_STAT: state <= S_CHK_STAT;
        S_CHK_STAT: begin
          if (evt_flag) begin
            if (evt_err_hit) begin
              stat_q <= XS_BUSERR;
              rd_q   <= '0;
            end else begin
              stat_q <= XS_OK;
              rd_q   <= wr_q ? 16'h0000 : pick_read(reg_rdata, word_q);
            end
            state <= S_RESTORE;
          end else if (tmr_exp) begin
            stat_q <= XS_TIMEOUT;
            rd_q   <= '0;
            state  <= S_RESTORE;
          end else begin
            state  <= S_RD_STAT;
          end
        end
        S_RESTORE: state <= S_FIN;
        S_FIN:     state <= S_IDLE;
        default:   state <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state != S_IDLE);
  assign done        = (state == S_FIN);
  assign rd_data     = rd_q;
  assign status      = stat_q;
  assign settle_warn = warn_q;
endmodule

// File: rtl/smbseq_chk.sv
module smbseq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [1:0]  status,
  input logic        reg_en,
  input logic        reg_we,
  input logic [1:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        evt_restore,
  input logic        evt_cmd_wr
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R10
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R1
  restore_last_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(evt_restore));
  // R7
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> status != 2'd3);
  // R4
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !reg_en);
  // R4
  sel_code_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_en |-> reg_sel != 2'd3);
  // R3
  trigger_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmd_wr |-> (reg_we && reg_sel == 2'd1 && reg_wdata[31]));
  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && start) |=> busy);
endmodule

bind smbus_xfer_seq smbseq_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .status      (status),
  .reg_en      (reg_en),
  .reg_we      (reg_we),
  .reg_sel     (reg_sel),
  .reg_wdata   (reg_wdata),
  .evt_restore (evt_restore),
  .evt_cmd_wr  (evt_cmd_wr)
);

// File: tb/test_smbus_xfer_seq.sv
module test_smbus_xfer_seq;
  localparam int TPM      = 4;
  localparam int DONE_CYC = 35 * TPM;
  localparam logic [31:0] INIT_CTRL = 32'h5400_0A5F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] tgt_addr = '0, cmd_byte = '0;
  logic [15:0] wr_data = '0;
  logic is_word = 1'b0, is_write = 1'b0;
  logic busy, done, settle_warn, reg_en, reg_we;
  logic [15:0] rd_data;
  logic [1:0] status, reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] m_rdata;

  always #4 clk = ~clk;

  smbus_xfer_seq #(.TICKS_PER_MS(TPM), .POLL_MS(10), .POLL_TRIES(4), .DONE_MS(35)) i_smbus_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tgt_addr(tgt_addr), .cmd_byte(cmd_byte),
    .wr_data(wr_data), .is_word(is_word), .is_write(is_write), .busy(busy), .done(done),
    .rd_data(rd_data), .status(status), .settle_warn(settle_warn), .reg_en(reg_en),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(m_rdata));

  // controller model configuration
  int m_busy = 0, m_after = 0;
  logic m_err = 1'b0, m_wr = 1'b0;
  logic [15:0] m_rsp = '0;
  // controller model observations
  logic [31:0] ctrl_reg, first_ctrl, last_ctrl, cmd_cap;
  int n_ctrl_wr, n_cmd_wr, n_ops, pre_cnt, post_cnt;
  logic ord_bad;

  always @(posedge clk) begin
    if (!rst_n) begin
      ctrl_reg <= INIT_CTRL; m_rdata <= '0; first_ctrl <= '0; last_ctrl <= '0;
      cmd_cap <= '0; n_ctrl_wr <= 0; n_cmd_wr <= 0; n_ops <= 0; pre_cnt <= 0;
      post_cnt <= 0; ord_bad <= 1'b0;
    end else if (start && !busy) begin
      n_ctrl_wr <= 0; n_cmd_wr <= 0; n_ops <= 0; pre_cnt <= 0; post_cnt <= 0;
      ord_bad <= 1'b0;
    end else if (reg_en) begin
      n_ops <= n_ops + 1;
      if (reg_we) begin
        if (reg_sel == 2'd0) begin
          ctrl_reg <= reg_wdata; last_ctrl <= reg_wdata;
          if (n_ctrl_wr == 0) first_ctrl <= reg_wdata;
          n_ctrl_wr <= n_ctrl_wr + 1;
        end else if (reg_sel == 2'd1) begin
          if (n_ctrl_wr != 1 || pre_cnt == 0) ord_bad <= 1'b1;
          cmd_cap <= reg_wdata; n_cmd_wr <= n_cmd_wr + 1;
        end else ord_bad <= 1'b1;
      end else begin
        if (reg_sel == 2'd0) begin
          if (n_ops != 0) ord_bad <= 1'b1;
          m_rdata <= ctrl_reg;
        end else if (reg_sel == 2'd2) begin
          if (n_cmd_wr == 0) begin
            m_rdata <= (pre_cnt < m_busy) ? 32'h8000_0000 : 32'h0000_0000;
            pre_cnt <= pre_cnt + 1;
          end else begin
            if (m_after != 15 && post_cnt >= m_after)
              m_rdata <= {1'b0, m_err, ~m_wr, m_wr, 12'h000, m_rsp};
            else
              m_rdata <= {2'b00, m_wr, ~m_wr, 12'h000, m_rsp};
            post_cnt <= post_cnt + 1;
          end
        end else ord_bad <= 1'b1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_xfer(input logic [7:0] a, input logic [7:0] c, input logic [15:0] d,
                          input logic w, input logic r, output int cyc);
    @(negedge clk);
    tgt_addr = a; cmd_byte = c; wr_data = d; is_word = w; is_write = r; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cyc = 1;
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10: done actual 0 expected 1");
    end
  endtask

  // {addr, cmd, data, word, wr, busy_reads, after(15=never), err, rsp}
  localparam logic [57:0] VEC [10] = '{
    {8'hA0, 8'h12, 16'h0000, 1'b0, 1'b0, 3'd0, 4'd0,  1'b0, 16'h77C3},
    {8'h30, 8'h05, 16'h0000, 1'b1, 1'b0, 3'd1, 4'd2,  1'b0, 16'h1234},
    {8'hA4, 8'h40, 16'hBEEF, 1'b0, 1'b1, 3'd0, 4'd1,  1'b0, 16'h0000},
    {8'h32, 8'h01, 16'h1234, 1'b1, 1'b1, 3'd2, 4'd3,  1'b0, 16'h0000},
    {8'h6C, 8'h00, 16'h0000, 1'b0, 1'b1, 3'd0, 4'd0,  1'b1, 16'h0000},
    {8'h6A, 8'h22, 16'h0000, 1'b0, 1'b0, 3'd0, 4'd1,  1'b1, 16'hAB55},
    {8'hA0, 8'h33, 16'h0000, 1'b0, 1'b0, 3'd0, 4'd0,  1'b1, 16'h00FF},
    {8'hA2, 8'h10, 16'h00AA, 1'b0, 1'b1, 3'd0, 4'd15, 1'b0, 16'h0000},
    {8'h18, 8'h07, 16'h0000, 1'b1, 1'b0, 3'd4, 4'd0,  1'b0, 16'h8001},
    {8'h1E, 8'h02, 16'h0000, 1'b1, 1'b0, 3'd3, 4'd0,  1'b0, 16'hC0DE}
  };

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int cyc;
    logic [7:0] a;
    logic [15:0] d, rsp, ex_rd, ex_dfield;
    logic w, r, e;
    int bz, af;
    logic [1:0] ex_st;
    logic [31:0] ex_ctrl, ex_cmd;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 busy", {31'b0, busy}, 32'd0);
    chk("R12 done", {31'b0, done}, 32'd0);
    chk("R12 reg_en", {31'b0, reg_en}, 32'd0);
    chk("R12 outputs", {13'b0, settle_warn, status, rd_data}, 32'd0);

    for (int i = 0; i < 10; i++) begin
      a = VEC[i][57:50]; d = VEC[i][41:26]; w = VEC[i][25]; r = VEC[i][24];
      bz = int'(VEC[i][23:21]); af = int'(VEC[i][20:17]); e = VEC[i][16]; rsp = VEC[i][15:0];
      m_busy = bz; m_after = af; m_err = e; m_wr = r; m_rsp = rsp;

      ex_ctrl = (INIT_CTRL & 32'h0BFF_FDFF) | (32'(a >> 4) << 28) | 32'h0800_0000;
      if (!r) ex_dfield = 16'h0000;
      else if (w) ex_dfield = 16'((d >> 8) | (d << 8));
      else ex_dfield = d & 16'h00FF;
      ex_cmd = 32'h8000_0000 | (32'(w) << 29) | (32'(r) << 27) | (32'((a >> 1) & 8'h07) << 24)
               | (32'(VEC[i][49:42]) << 16) | 32'(ex_dfield);
      if (af == 15) ex_st = 2'd1;
      else if (e && (a >> 4) != 8'h06) ex_st = 2'd2;
      else ex_st = 2'd0;
      if (ex_st == 2'd0 && !r) ex_rd = w ? 16'((rsp << 8) | (rsp >> 8)) : (rsp & 16'h00FF);
      else ex_rd = 16'h0000;

      run_xfer(a, VEC[i][49:42], d, w, r, cyc);
      chk($sformatf("R6 R7 R8 status v%0d", i), {30'b0, status}, {30'b0, ex_st});
      chk($sformatf("R9 rd_data v%0d", i), {16'b0, rd_data}, {16'b0, ex_rd});
      chk($sformatf("R2 ctrl v%0d", i), first_ctrl, ex_ctrl);
      chk($sformatf("R3 cmd v%0d", i), cmd_cap, ex_cmd);
      chk($sformatf("R1 restore v%0d", i), last_ctrl, INIT_CTRL);
      chk($sformatf("R4 counts v%0d", i), {ord_bad, 7'd0, 8'(n_ctrl_wr), 8'(n_cmd_wr), 8'd0},
          {1'b0, 7'd0, 8'd2, 8'd1, 8'd0});
      chk($sformatf("R5 warn v%0d", i), {31'b0, settle_warn}, {31'b0, bz >= 4});
      chk($sformatf("R5 busy reads v%0d", i), 32'(pre_cnt), (bz >= 4) ? 32'd4 : 32'(bz + 1));
      if (i == 0) chk("R10 fast latency", 32'(cyc - 1), 32'd9);
      if (af == 15) chk("R7 window", {31'b0, cyc >= DONE_CYC}, 32'd1);
      @(negedge clk);
      chk($sformatf("R10 pulse v%0d", i), {30'b0, done, busy}, 32'd0);
    end

    // R11: a start during a transfer is ignored
    m_busy = 0; m_after = 3; m_err = 1'b0; m_wr = 1'b1; m_rsp = '0;
    @(negedge clk);
    tgt_addr = 8'hA6; cmd_byte = 8'h09; wr_data = 16'h0011; is_word = 1'b0; is_write = 1'b1;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    tgt_addr = 8'h50; cmd_byte = 8'hEE; wr_data = 16'hFFFF; is_word = 1'b1; is_write = 1'b0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 4000) begin @(negedge clk); cyc++; end
    chk("R11 cmd of first request", cmd_cap, 32'h8B09_0011);
    chk("R11 single command", 32'(n_cmd_wr), 32'd1);
    repeat (12) @(negedge clk);
    chk("R11 no queued transfer", {31'b0, busy}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule